// File: doc/BRIEF.md
# Serial Management Slave for a Switch Register File

This block terminates the two-wire serial management bus on the switch side. It takes the externally supplied management clock as its own clock, samples the data line on every rising edge, and follows the framing of each management cycle: an optional run of ones as preamble, a two-bit start pattern, a two-bit opcode, a five-bit PHY address, a five-bit register address, a two-bit turnaround and a sixteen-bit data word. Every field is sent most significant bit first.

Frames whose PHY address falls in a window of consecutive addresses (by default 0 to 4) reach a simple register port. A write produces a one-cycle write strobe with address and data. A read raises a one-cycle read strobe when the register address is complete, samples the returned word on the next edge, and drives the line back through an output-enable: released for the first turnaround bit, a zero for the second, then the sixteen data bits. After power-up the slave ignores any frame that does not follow at least 32 consecutive ones. Once one well-formed frame with such a preamble has completed, it accepts frames that begin with the start pattern straight from idle.

Top module: `mdioSlave`

## Requirements
- R1: While reset is asserted, and on its release, mdioOe, regWrStb and regRdStb are low, and a full preamble is required again before any frame is accepted.
- R2: Until the first complete frame with a full preamble has ended since reset, a 0 that follows fewer than PRE_LEN (32) consecutive ones is not a start bit, and the whole frame has no effect: no strobe, no drive.
- R3: A write frame is start 0 then 1 and opcode 0 then 1 (as sent on the line), followed by a 5-bit PHY address, a 5-bit register address, two turnaround bits and 16 data bits, all MSB first. For an address in range, regWrStb is high for exactly the one clock cycle after the rising edge that samples the 16th data bit, with regPhy, regAddr and regWrData holding the frame's fields.
- R4: A read frame carries opcode 1 then 0. For an address in range, regRdStb is high for exactly the one cycle after the edge that samples the last register-address bit, with regPhy and regAddr valid; regRdData is taken at the next rising edge.
- R5: On an accepted read, mdioOe stays low through the first turnaround bit, goes high after the edge that samples that bit with mdioOut at 0, then presents the read word MSB first, one bit per edge, and falls after the edge that samples the last data bit: 17 cycles of drive in all.
- R6: For PHY addresses outside PHY_BASE to PHY_BASE+PHY_COUNT-1 (0 to 4 by default) the frame is consumed but no strobe fires and mdioOe stays low.
- R7: After a well-formed frame (either opcode, any PHY address) that followed a full preamble has ended, a frame whose start pattern follows the previous frame or idle ones directly, with fewer than 32 ones or none, is accepted.
- R8: A start pattern of 0 then 0, or an opcode of 00 or 11, abandons the frame without strobe or drive; the slave goes back to hunting and its run-of-ones count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock from the master; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| mdioIn | input | 1 | Resolved level of the serial data line |
| mdioOut | output | 1 | Value the slave puts on the line while mdioOe is high |
| mdioOe | output | 1 | Tri-state enable for mdioOut |
| regPhy | output | ADDR_W | PHY address of the current access |
| regAddr | output | ADDR_W | Register address of the current access |
| regWrData | output | DATA_W | Data word of a write |
| regWrStb | output | 1 | One-cycle write strobe |
| regRdStb | output | 1 | One-cycle read request |
| regRdData | input | DATA_W | Read word returned by the register file, valid the cycle after regRdStb |

## Verification
The bench builds the block with its default parameters: a 32-one preamble threshold, a window of PHY addresses from 0 to 4, five-bit addresses and sixteen-bit data. These values place the lowest and highest accepted addresses next to the first rejected one (5) and the all-ones address (31), and they put a preamble of 31 ones directly beside one of 32. They also allow an invalid start and both invalid opcodes to be placed before the first full preamble and between frames with no preamble. A reset in the middle of the run shows that preamble suppression is withdrawn again.

// File: rtl/mdioPkg.sv
package mdioPkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_OP,
    ST_PHY,
    ST_REG,
    ST_TA,
    ST_DATA
  } mdioState_e;

  // strobes from the frame sequencer to the datapath, all for the current edge
  typedef struct packed {
    logic shiftEn;    // shift the sampled bit into the receive shifter
    logic latchPhy;   // last PHY address bit sampled
    logic latchReg;   // last register address bit sampled
    logic rdFire;     // raise the read request
    logic loadRd;     // take the returned read word
    logic driveZero;  // start driving, turnaround zero
    logic emitBit;    // put next read bit on the line
    logic dropLine;   // stop driving
    logic wrFire;     // raise the write strobe
  } mdioStb_t;

endpackage

// File: rtl/mdioCtrl.sv
module mdioCtrl
  import mdioPkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16
) (
  input  logic     mdc,
  input  logic     rstN,
  input  logic     mdioIn,
  input  logic     phyHit,
  output mdioStb_t stb
);

  localparam int CNT_W   = $clog2(PRE_LEN + 1);
  localparam int FLD_MAX = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int BIT_W   = $clog2(FLD_MAX);
  localparam logic [CNT_W-1:0] PRE_FULL  = CNT_W'(PRE_LEN);
  localparam logic [BIT_W-1:0] ADDR_LAST = BIT_W'(ADDR_W - 1);
  localparam logic [BIT_W-1:0] DATA_LAST = BIT_W'(DATA_W - 1);

  mdioState_e       state, stateN;
  logic [BIT_W-1:0] bitCnt, bitCntN;
  logic [CNT_W-1:0] oneCnt;
  logic             seenFull, seenFullN;
  logic             fullPre, fullPreN;
  logic             isRead, isReadN;
  logic             opHi;
  logic             preDone;
  logic             accessOn;

  assign preDone  = (oneCnt == PRE_FULL);
  assign accessOn = isRead && phyHit;

  always_comb begin
    stb       = '0;
    stateN    = state;
    bitCntN   = bitCnt + 1'b1;
    seenFullN = seenFull;
    fullPreN  = fullPre;
    isReadN   = isRead;
    unique case (state)
      ST_HUNT: begin
        bitCntN = '0;
        if (!mdioIn && (preDone || seenFull)) begin
          stateN   = ST_START;
          fullPreN = preDone;
        end
      end
      ST_START: begin
        bitCntN = '0;
        stateN  = mdioIn ? ST_OP : ST_HUNT;
      end
      ST_OP: begin
        if (bitCnt != '0) begin
          bitCntN = '0;
          // a legal opcode has two different bits; the first one tells read
          if (opHi != mdioIn) begin
            isReadN = opHi;
            stateN  = ST_PHY;
          end else begin
            stateN = ST_HUNT;
          end
        end
      end
      ST_PHY: begin
        stb.shiftEn = 1'b1;
        if (bitCnt == ADDR_LAST) begin
          stb.latchPhy = 1'b1;
          bitCntN      = '0;
          stateN       = ST_REG;
        end
      end
      ST_REG: begin
        stb.shiftEn = 1'b1;
        if (bitCnt == ADDR_LAST) begin
          stb.latchReg = 1'b1;
          stb.rdFire   = accessOn;
          bitCntN      = '0;
          stateN       = ST_TA;
        end
      end
      ST_TA: begin
        if (bitCnt == '0) begin
          stb.loadRd    = accessOn;
          stb.driveZero = accessOn;
        end else begin
          stb.emitBit = accessOn;
          bitCntN     = '0;
          stateN      = ST_DATA;
        end
      end
      ST_DATA: begin
        stb.shiftEn = 1'b1;
        if (bitCnt == DATA_LAST) begin
          stb.dropLine = 1'b1;
          stb.wrFire   = !isRead && phyHit;
          seenFullN    = seenFull | fullPre;
          bitCntN      = '0;
          stateN       = ST_HUNT;
        end else begin
          stb.emitBit = accessOn;
        end
      end
      default: stateN = ST_HUNT;
    endcase
  end

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      bitCnt   <= '0;
      oneCnt   <= '0;
      seenFull <= 1'b0;
      fullPre  <= 1'b0;
      isRead   <= 1'b0;
      opHi     <= 1'b0;
    end else begin
      state    <= stateN;
      bitCnt   <= bitCntN;
      seenFull <= seenFullN;
      fullPre  <= fullPreN;
      isRead   <= isReadN;
      opHi     <= mdioIn;
      // ones are counted only while hunting; any zero or frame activity restarts
      if (state == ST_HUNT && mdioIn) begin
        if (!preDone) oneCnt <= oneCnt + 1'b1;
      end else begin
        oneCnt <= '0;
      end
    end
  end

endmodule

// File: rtl/mdioDatapath.sv
module mdioDatapath
  import mdioPkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int PHY_BASE  = 0,
  parameter int PHY_COUNT = 5
) (
  input  logic              mdc,
  input  logic              rstN,
  input  logic              mdioIn,
  input  mdioStb_t          stb,
  input  logic [DATA_W-1:0] regRdData,
  output logic              phyHit,
  output logic [ADDR_W-1:0] regPhy,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrStb,
  output logic              regRdStb,
  output logic              mdioOut,
  output logic              mdioOe
);

  localparam logic [ADDR_W:0] BASE = (ADDR_W + 1)'(PHY_BASE);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W + 1)'(PHY_COUNT);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] rdShift;
  logic [ADDR_W:0]   phyOfs;

  // below the base the subtraction wraps past SPAN, so one compare covers both ends
  assign phyOfs = {1'b0, regPhy} - BASE;
  assign phyHit = (phyOfs < SPAN);

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      rdShift   <= '0;
      regPhy    <= '0;
      regAddr   <= '0;
      regWrData <= '0;
      regWrStb  <= 1'b0;
      regRdStb  <= 1'b0;
      mdioOut   <= 1'b1;
      mdioOe    <= 1'b0;
    end else begin
      regWrStb <= stb.wrFire;
      regRdStb <= stb.rdFire;
      if (stb.shiftEn)  shiftReg  <= {shiftReg[DATA_W-2:0], mdioIn};
      if (stb.latchPhy) regPhy    <= {shiftReg[ADDR_W-2:0], mdioIn};
      if (stb.latchReg) regAddr   <= {shiftReg[ADDR_W-2:0], mdioIn};
      if (stb.wrFire)   regWrData <= {shiftReg[DATA_W-2:0], mdioIn};
      if (stb.loadRd)   rdShift   <= regRdData;
      if (stb.driveZero) begin
        mdioOe  <= 1'b1;
        mdioOut <= 1'b0;
      end else if (stb.emitBit) begin
        mdioOe  <= 1'b1;
        mdioOut <= rdShift[DATA_W-1];
        rdShift <= {rdShift[DATA_W-2:0], 1'b0};
      end else if (stb.dropLine) begin
        mdioOe  <= 1'b0;
        mdioOut <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mdioSlave.sv
module mdioSlave
  import mdioPkg::*;
#(
  parameter int PRE_LEN   = 32,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int PHY_BASE  = 0,
  parameter int PHY_COUNT = 5
) (
  input  logic              mdc,
  input  logic              rstN,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic [ADDR_W-1:0] regPhy,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrStb,
  output logic              regRdStb,
  input  logic [DATA_W-1:0] regRdData
);

  mdioStb_t stb;
  logic     phyHit;

  mdioCtrl #(
    .PRE_LEN(PRE_LEN),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .mdc   (mdc),
    .rstN  (rstN),
    .mdioIn(mdioIn),
    .phyHit(phyHit),
    .stb   (stb)
  );

  mdioDatapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PHY_BASE (PHY_BASE),
    .PHY_COUNT(PHY_COUNT)
  ) u_dp (
    .mdc      (mdc),
    .rstN     (rstN),
    .mdioIn   (mdioIn),
    .stb      (stb),
    .regRdData(regRdData),
    .phyHit   (phyHit),
    .regPhy   (regPhy),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regWrStb (regWrStb),
    .regRdStb (regRdStb),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe)
  );

endmodule

// File: rtl/mdioSlaveChecker.sv
module mdioSlaveChecker #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int PHY_BASE  = 0,
  parameter int PHY_COUNT = 5
) (
  input logic              mdc,
  input logic              rstN,
  input logic              mdioOe,
  input logic              mdioOut,
  input logic              regRdStb,
  input logic              regWrStb,
  input logic [ADDR_W-1:0] regPhy
);

  localparam int RUN_W = $clog2(DATA_W + 3);
  localparam logic [RUN_W-1:0] RUN_LEN = RUN_W'(DATA_W + 1);

  logic [RUN_W-1:0] oeRun;
  int               phyInt;

  assign phyInt = int'(regPhy);

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN)       oeRun <= '0;
    else if (mdioOe) oeRun <= oeRun + 1'b1;
    else             oeRun <= '0;
  end

  AST_WR_ONE_CYCLE: assert property (@(posedge mdc) disable iff (!rstN)
    regWrStb |=> !regWrStb); // R3

  AST_STB_EXCLUSIVE: assert property (@(posedge mdc) disable iff (!rstN)
    !(regRdStb && regWrStb)); // R3

  AST_RD_ONE_CYCLE: assert property (@(posedge mdc) disable iff (!rstN)
    regRdStb |=> !regRdStb); // R4

  AST_TA_DRIVES_ZERO: assert property (@(posedge mdc) disable iff (!rstN)
    regRdStb |=> (mdioOe && !mdioOut)); // R5

  AST_OE_SPAN: assert property (@(posedge mdc) disable iff (!rstN)
    $fell(mdioOe) |-> (oeRun == RUN_LEN)); // R5

  AST_OE_AFTER_READ: assert property (@(posedge mdc) disable iff (!rstN)
    $rose(mdioOe) |-> $past(regRdStb)); // R6

  AST_PHY_IN_RANGE: assert property (@(posedge mdc) disable iff (!rstN)
    (regRdStb || regWrStb) |-> (phyInt >= PHY_BASE && phyInt < PHY_BASE + PHY_COUNT)); // R6

endmodule

bind mdioSlave mdioSlaveChecker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PHY_BASE (PHY_BASE),
  .PHY_COUNT(PHY_COUNT)
) u_check (
  .mdc     (mdc),
  .rstN    (rstN),
  .mdioOe  (mdioOe),
  .mdioOut (mdioOut),
  .regRdStb(regRdStb),
  .regWrStb(regWrStb),
  .regPhy  (regPhy)
);

// File: tb/mdioSlave_bench.sv
module mdioSlave_bench;

  typedef struct packed {
    logic        oe;
    logic        out;
    logic        rd;
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  ra;
    logic [15:0] data;
  } exp_t;

  localparam exp_t IDLE = '0;

  logic        mdc = 1'b0;
  logic        rstN = 1'b0;
  logic        masterBit = 1'b1;
  logic        mdioIn;
  logic        mdioOut, mdioOe;
  logic [4:0]  regPhy, regAddr;
  logic [15:0] regWrData, regRdData;
  logic        regWrStb, regRdStb;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  bit    seenFull = 0;
  int    onesRun = 0;
  bit    havePend = 0;
  exp_t  pendExp;
  string pendTag;

  logic  drvQ[$];
  exp_t  expQ[$];
  string tagQ[$];

  always #5 mdc = ~mdc;

  function automatic logic [15:0] rdModel(input logic [4:0] p, input logic [4:0] r);
    return {r, p, 6'h2D} ^ 16'h9C31;
  endfunction

  assign regRdData = rdModel(regPhy, regAddr);
  // line resolution: slave drive wins, otherwise the master's level (1 = released)
  assign mdioIn = mdioOe ? mdioOut : masterBit;

  mdioSlave u_mdioSlave (
    .mdc      (mdc),
    .rstN     (rstN),
    .mdioIn   (mdioIn),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe),
    .regPhy   (regPhy),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regWrStb (regWrStb),
    .regRdStb (regRdStb),
    .regRdData(regRdData)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic checkOut(input exp_t e, input string tag);
    chk(mdioOe === e.oe, tag, "mdioOe", int'(mdioOe), int'(e.oe));
    if (e.oe) chk(mdioOut === e.out, tag, "mdioOut", int'(mdioOut), int'(e.out));
    chk(regRdStb === e.rd, tag, "regRdStb", int'(regRdStb), int'(e.rd));
    chk(regWrStb === e.wr, tag, "regWrStb", int'(regWrStb), int'(e.wr));
    if (e.rd || e.wr) begin
      chk(regPhy === e.phy, tag, "regPhy", int'(regPhy), int'(e.phy));
      chk(regAddr === e.ra, tag, "regAddr", int'(regAddr), int'(e.ra));
    end
    if (e.wr) chk(regWrData === e.data, tag, "regWrData", int'(regWrData), int'(e.data));
  endtask

  task automatic push(input logic b, input exp_t e, input string tag);
    drvQ.push_back(b);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // a bit the slave must not react to; hunting keeps counting ones
  task automatic quietBit(input logic b, input string tag);
    push(b, IDLE, tag);
    onesRun = b ? onesRun + 1 : 0;
  endtask

  task automatic frame(input int preLen, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd,
                       input string tag);
    bit armed, fullPre, hit, rd, acc;
    logic [15:0] rdv;
    exp_t e;
    fullPre = (onesRun + preLen >= 32);
    armed   = seenFull || fullPre;
    hit     = (phy <= 5'd4);
    rd      = (op == 2'b10);
    acc     = rd && hit;
    rdv     = rdModel(phy, ra);
    for (int i = 0; i < preLen; i++) quietBit(1'b1, tag);
    if (!armed) begin
      quietBit(st[1], tag); quietBit(st[0], tag);
      quietBit(op[1], tag); quietBit(op[0], tag);
      for (int i = 4; i >= 0; i--) quietBit(phy[i], tag);
      for (int i = 4; i >= 0; i--) quietBit(ra[i], tag);
      quietBit(1'b1, tag); quietBit(rd ? 1'b1 : 1'b0, tag);
      for (int i = 15; i >= 0; i--) quietBit(rd ? 1'b1 : wd[i], tag);
      return;
    end
    push(st[1], IDLE, tag);
    if (st[0] == 1'b0) begin
      push(1'b0, IDLE, "R8");
      onesRun = 0;
      return;
    end
    push(1'b1, IDLE, tag);
    push(op[1], IDLE, tag);
    if (op[1] == op[0]) begin
      push(op[0], IDLE, "R8");
      onesRun = 0;
      return;
    end
    push(op[0], IDLE, tag);
    for (int i = 4; i >= 0; i--) push(phy[i], IDLE, tag);
    for (int i = 4; i >= 1; i--) push(ra[i], IDLE, tag);
    e = IDLE; e.rd = acc; e.phy = phy; e.ra = ra;
    push(ra[0], e, tag);
    e = IDLE; e.oe = acc; e.out = 1'b0;
    push(1'b1, e, hit ? "R5" : "R6");
    e = IDLE; e.oe = acc; e.out = rdv[15];
    push(rd ? 1'b1 : 1'b0, e, hit ? "R5" : "R6");
    for (int j = 0; j < 15; j++) begin
      e = IDLE; e.oe = acc; e.out = rdv[14-j];
      push(rd ? 1'b1 : wd[15-j], e, hit ? "R5" : "R6");
    end
    e = IDLE; e.wr = !rd && hit; e.phy = phy; e.ra = ra; e.data = wd;
    push(rd ? 1'b1 : wd[0], e, tag);
    seenFull = seenFull | fullPre;
    onesRun = 0;
  endtask

  // driver and comparator: outputs after edge k are checked at the next falling edge
  always @(negedge mdc) begin
    if (!rstN) begin
      masterBit = 1'b1;
      havePend  = 0;
    end else begin
      if (havePend) checkOut(pendExp, pendTag);
      if (drvQ.size() > 0) begin
        masterBit = drvQ.pop_front();
        pendExp   = expQ.pop_front();
        pendTag   = tagQ.pop_front();
      end else begin
        masterBit = 1'b1;
        pendExp   = IDLE;
        pendTag   = "R5";
      end
      havePend = 1;
    end
  end

  initial begin
    repeat (200000) @(posedge mdc);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge mdc);
    // R1: quiet outputs under reset
    chk(mdioOe === 1'b0, "R1", "mdioOe", int'(mdioOe), 0);
    chk(regWrStb === 1'b0, "R1", "regWrStb", int'(regWrStb), 0);
    chk(regRdStb === 1'b0, "R1", "regRdStb", int'(regRdStb), 0);

    seenFull = 0; onesRun = 0;
    frame(31, 2'b01, 2'b01, 5'd4, 5'h02, 16'h1234, "R2");  // one short of the threshold
    frame(32, 2'b01, 2'b11, 5'd1, 5'h00, 16'h0000, "R8");  // opcode 11 after full preamble
    frame(31, 2'b01, 2'b01, 5'd1, 5'h04, 16'h5A5A, "R8");  // count restarted by the abort
    frame(32, 2'b01, 2'b01, 5'd4, 5'h11, 16'hBEEF, "R3");  // first accepted frame
    frame(0,  2'b01, 2'b10, 5'd0, 5'h03, 16'h0000, "R7");  // no preamble, lowest address
    frame(0,  2'b01, 2'b10, 5'd5, 5'h0A, 16'h0000, "R6");  // first address outside
    frame(0,  2'b01, 2'b01, 5'd31, 5'h1F, 16'hFFFF, "R6");
    frame(0,  2'b01, 2'b10, 5'd2, 5'h1F, 16'h0000, "R4");
    frame(0,  2'b01, 2'b01, 5'd1, 5'h00, 16'h0001, "R7");
    frame(0,  2'b00, 2'b00, 5'd0, 5'h00, 16'h0000, "R8");  // bad start pattern
    frame(0,  2'b01, 2'b10, 5'd3, 5'h07, 16'h0000, "R4");
    frame(0,  2'b01, 2'b00, 5'd0, 5'h00, 16'h0000, "R8");  // opcode 00
    frame(0,  2'b01, 2'b10, 5'd4, 5'h1A, 16'h0000, "R4");  // highest address
    frame(2,  2'b01, 2'b01, 5'd0, 5'h15, 16'h8001, "R3");

    @(posedge mdc); #1 rstN = 1'b1;
    while (drvQ.size() != 0) @(negedge mdc);
    repeat (4) @(negedge mdc);

    // R1: reset withdraws preamble suppression
    @(posedge mdc); #1 rstN = 1'b0;
    repeat (2) @(negedge mdc);
    chk(mdioOe === 1'b0, "R1", "mdioOe", int'(mdioOe), 0);
    seenFull = 0; onesRun = 0;
    frame(0,  2'b01, 2'b01, 5'd2, 5'h05, 16'hC3C3, "R1");
    frame(32, 2'b01, 2'b10, 5'd1, 5'h0C, 16'h0000, "R1");
    @(posedge mdc); #1 rstN = 1'b1;
    while (drvQ.size() != 0) @(negedge mdc);
    repeat (4) @(negedge mdc);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule